// File: doc/BRIEF.md
# Shared Parameter Memory Arbiter

The arbiter decides, every clock cycle, which of four requesters may use the single port of a shared parameter memory. The four requesters are two processing engines, a controller that moves parameter pairs coherently, and a host port. The grant is combinational from the current requests and a small amount of registered history. The granted requester's address, write enable and write data are steered to the memory port in the same cycle.

Engines normally access parameters in pairs. The arbiter keeps a modulo-2 count of each engine's consecutive accesses. While an engine is between the first and second access of a pair, it holds priority over the host and over any transfer that has not yet started. At a pair boundary, the engine yields to a waiting host or transfer. It also yields after a cycle in which it made no request, because that idle cycle restarts its count. The two engines may interleave with each other. Once the transfer controller has been granted the first access of a transfer, it wins every cycle in which it requests, until it is granted an access flagged as the last one.

Top module: `pmem_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and exactly one is high whenever any request is present. Bit 0 is engine 0, bit 1 is engine 1, bit 2 is the transfer controller and bit 3 is the host.
- R2: In the same cycle, `mem_en` equals the OR of `gnt`, and `mem_addr`, `mem_we` and `mem_wdata` carry the granted requester's inputs. They carry zero when no grant is given.
- R3: An engine that has made an odd number of consecutive granted accesses and is still requesting wins over the host and over a transfer that is not in progress.
- R4: Once an engine completes the second access of a pair, a pending host or new transfer request wins the next cycle.
- R5: A cycle in which an engine does not request resets its pair count, so its next access is the first of a new pair and does not hold priority.
- R6: During an unbroken run of grants to one engine, the third and fourth accesses form a new pair: the fourth access still beats a waiting host.
- R7: When engines hold priority and both request, the grant alternates between them, starting with engine 0 after reset.
- R8: After the transfer controller has been granted an access without `xfr_last`, its requests win over both engines, including an engine in mid-pair, and over the host.
- R9: With no engine holding priority and no transfer in progress, a host request beats a transfer request.
- R10: A granted transfer access with `xfr_last` high ends the in-progress state, so the next cycle's arbitration follows R3 and R9 again.
- R11: After synchronous reset, both pair counts are zero and no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng0_req | input | 1 | Engine 0 requests the memory this cycle |
| eng1_req | input | 1 | Engine 1 requests the memory this cycle |
| xfr_req | input | 1 | Transfer controller requests the memory |
| xfr_last | input | 1 | Current transfer access is the final one |
| host_req | input | 1 | Host requests the memory |
| req_addr | input | 4*ADDR_W | Per-requester address, indexed like `gnt` |
| req_we | input | 4 | Per-requester write enable |
| req_wdata | input | 4*DATA_W | Per-requester write data |
| gnt | output | 4 | One-hot grant |
| mem_en | output | 1 | Memory port access strobe |
| mem_addr | output | ADDR_W | Memory port address |
| mem_we | output | 1 | Memory port write enable |
| mem_wdata | output | DATA_W | Memory port write data |

## Verification
Grant and memory-port results depend only on the current cycle's requests and on state updated at the previous edge, so each is due in the cycle the stimulus is applied. The driver applies one cycle of requests just after a falling edge and queues the expected grant for that cycle. The monitor compares a few nanoseconds later, before the next rising edge. History effects such as pair counts, alternation and the transfer lock are checked by chaining cycles, so the expected grant of each cycle reflects the grants queued before it.

// File: rtl/pmarb_pkg.sv
package pmarb_pkg;
    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned NUM_ENG = 2;
    localparam int unsigned CNT_W   = 2;

    typedef enum logic [1:0] {
        SRC_ENG0 = 2'd0,
        SRC_ENG1 = 2'd1,
        SRC_XFR  = 2'd2,
        SRC_HOST = 2'd3
    } src_e;

    typedef struct packed {
        logic                host;
        logic                xfr;
        logic [NUM_ENG-1:0]  eng;
    } req_vec_t;

    typedef struct packed {
        logic valid;
        src_e src;
    } pick_t;

    function automatic logic [NUM_SRC-1:0] src_onehot(input pick_t p);
        logic [NUM_SRC-1:0] v;
        v = '0;
        if (p.valid) v[p.src] = 1'b1;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] pair_step(input logic [CNT_W-1:0] c);
        return (c == CNT_W'(1)) ? '0 : c + CNT_W'(1);
    endfunction
endpackage

// File: rtl/pmarb_eng_track.sv
module pmarb_eng_track
    import pmarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic granted,
    output logic mid_pair
);
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)            run_cnt <= '0;
        else if (!req)      run_cnt <= '0;
        else if (granted)   run_cnt <= pair_step(run_cnt);
    end

    assign mid_pair = (run_cnt == CNT_W'(1));

    // R5
    idle_resets_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !mid_pair);
endmodule

// File: rtl/pmarb_xfr_lock.sv
module pmarb_xfr_lock (
    input  logic clk,
    input  logic rst,
    input  logic xfr_req,
    input  logic xfr_granted,
    input  logic xfr_last,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)              busy <= 1'b0;
        else if (xfr_granted) busy <= !xfr_last;
    end

    // R8
    busy_xfr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && xfr_req) |-> xfr_granted);

    // R10
    last_releases_chk: assert property (@(posedge clk) disable iff (rst)
        (xfr_granted && xfr_last) |=> !busy);
endmodule

// File: rtl/pmarb_pick.sv
module pmarb_pick
    import pmarb_pkg::*;
(
    input  req_vec_t           req,
    input  logic [NUM_ENG-1:0] mid,
    input  logic               xfr_busy,
    input  logic               last_eng,
    output pick_t              win
);
    logic eng_hold;
    logic both_eng;
    src_e eng_choice;

    always_comb begin
        eng_hold   = |(req.eng & mid);
        both_eng   = &req.eng;
        if (both_eng)      eng_choice = last_eng ? SRC_ENG0 : SRC_ENG1;
        else if (req.eng[0]) eng_choice = SRC_ENG0;
        else               eng_choice = SRC_ENG1;

        win.valid = 1'b1;
        if (xfr_busy && req.xfr)  win.src = SRC_XFR;
        else if (eng_hold)        win.src = eng_choice;
        else if (req.host)        win.src = SRC_HOST;
        else if (req.xfr)         win.src = SRC_XFR;
        else if (|req.eng)        win.src = eng_choice;
        else begin
            win.valid = 1'b0;
            win.src   = SRC_ENG0;
        end
    end
endmodule

// File: rtl/pmem_arbiter.sv
module pmem_arbiter
    import pmarb_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           eng0_req,
    input  logic                           eng1_req,
    input  logic                           xfr_req,
    input  logic                           xfr_last,
    input  logic                           host_req,
    input  logic [NUM_SRC-1:0][ADDR_W-1:0] req_addr,
    input  logic [NUM_SRC-1:0]             req_we,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] req_wdata,
    output logic [NUM_SRC-1:0]             gnt,
    output logic                           mem_en,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic                           mem_we,
    output logic [DATA_W-1:0]              mem_wdata
);
    req_vec_t           req;
    logic [NUM_ENG-1:0] mid;
    logic               xfr_busy;
    logic               last_eng;
    pick_t              win;

    assign req.eng  = {eng1_req, eng0_req};
    assign req.xfr  = xfr_req;
    assign req.host = host_req;

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        pmarb_eng_track u_track (
            .clk      (clk),
            .rst      (rst),
            .req      (req.eng[e]),
            .granted  (gnt[e]),
            .mid_pair (mid[e])
        );

        // R3
        mid_pair_holds_chk: assert property (@(posedge clk) disable iff (rst)
            (mid[e] && req.eng[e] && !xfr_busy) |-> (|gnt[NUM_ENG-1:0]));
    end

    pmarb_xfr_lock u_lock (
        .clk         (clk),
        .rst         (rst),
        .xfr_req     (xfr_req),
        .xfr_granted (gnt[SRC_XFR]),
        .xfr_last    (xfr_last),
        .busy        (xfr_busy)
    );

    pmarb_pick u_pick (
        .req      (req),
        .mid      (mid),
        .xfr_busy (xfr_busy),
        .last_eng (last_eng),
        .win      (win)
    );

    assign gnt = src_onehot(win);

    always_ff @(posedge clk) begin
        if (rst)                 last_eng <= 1'b1;
        else if (gnt[SRC_ENG0])  last_eng <= 1'b0;
        else if (gnt[SRC_ENG1])  last_eng <= 1'b1;
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (gnt[s]) begin
                mem_en    = 1'b1;
                mem_addr  = req_addr[s];
                mem_we    = req_we[s];
                mem_wdata = req_wdata[s];
            end
        end
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R1
    grant_when_asked_chk: assert property (@(posedge clk) disable iff (rst)
        (eng0_req || eng1_req || xfr_req || host_req) |-> (gnt != '0));

    // R2
    port_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en == (|gnt));
endmodule

// File: tb/pmem_arbiter_bench.sv
module pmem_arbiter_bench;
    localparam int AW = 10;
    localparam int DW = 32;

    typedef struct {
        logic [3:0] g;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic e0 = 0, e1 = 0, x = 0, xl = 0, h = 0;
    logic [3:0][AW-1:0] req_addr;
    logic [3:0]         req_we;
    logic [3:0][DW-1:0] req_wdata;
    logic [3:0]         gnt;
    logic               mem_en;
    logic [AW-1:0]      mem_addr;
    logic               mem_we;
    logic [DW-1:0]      mem_wdata;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    pmem_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_pmem_arbiter (
        .clk(clk), .rst(rst),
        .eng0_req(e0), .eng1_req(e1), .xfr_req(x), .xfr_last(xl), .host_req(h),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .gnt(gnt), .mem_en(mem_en), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    function automatic logic [AW-1:0] addr_of(input int s);
        return AW'(16 * (s + 1) + s);
    endfunction

    function automatic logic [DW-1:0] data_of(input int s);
        return DW'(32'hA500_0000 + s * 32'h111);
    endfunction

    initial begin
        for (int s = 0; s < 4; s++) begin
            req_addr[s]  = addr_of(s);
            req_we[s]    = s[0];
            req_wdata[s] = data_of(s);
        end
    end

    task automatic drive(input logic a0, input logic a1, input logic ax,
                         input logic axl, input logic ah,
                         input logic [3:0] eg, input string tag);
        exp_t it;
        @(negedge clk);
        e0 = a0; e1 = a1; x = ax; xl = axl; h = ah;
        it.g = eg;
        it.tag = tag;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        exp_t it;
        logic [AW-1:0] ea;
        logic          ewe;
        logic [DW-1:0] ed;
        #3;
        if (q.size() > 0) begin
            it = q.pop_front();
            ea = '0; ewe = 1'b0; ed = '0;
            for (int s = 0; s < 4; s++)
                if (it.g[s]) begin
                    ea = addr_of(s); ewe = s[0]; ed = data_of(s);
                end
            checks++;
            if (gnt !== it.g) begin
                errors++;
                $display("FAIL %s gnt actual=%b expected=%b", it.tag, gnt, it.g);
            end
            checks++;
            if (mem_en !== (|it.g) || mem_addr !== ea || mem_we !== ewe || mem_wdata !== ed) begin
                errors++;
                $display("FAIL R2 port (%s) actual en=%b addr=%h we=%b data=%h expected en=%b addr=%h we=%b data=%h",
                         it.tag, mem_en, mem_addr, mem_we, mem_wdata, |it.g, ea, ewe, ed);
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 / R1: idle after reset, no grant
        drive(0,0,0,0,0, 4'b0000, "R11 idle");
        // R3 / R4 / R11: first access after reset, then hold, then yield
        drive(1,0,0,0,0, 4'b0001, "R11 first");
        drive(1,0,0,0,1, 4'b0001, "R3 mid-pair beats host");
        drive(1,0,0,0,1, 4'b1000, "R4 host after pair");
        // R6: run of four engine accesses
        drive(1,0,0,0,0, 4'b0001, "R6 a1");
        drive(1,0,0,0,0, 4'b0001, "R6 a2");
        drive(1,0,0,0,0, 4'b0001, "R6 a3");
        drive(1,0,0,0,1, 4'b0001, "R6 a4 beats host");
        drive(1,0,0,0,1, 4'b1000, "R4 host after second pair");
        drive(0,0,0,0,0, 4'b0000, "R1 idle");
        // R5: idle cycle breaks the pair
        drive(1,0,0,0,0, 4'b0001, "R5 first");
        drive(0,0,0,0,0, 4'b0000, "R5 gap");
        drive(1,0,0,0,1, 4'b1000, "R5 no hold after gap");
        drive(1,0,0,0,0, 4'b0001, "R5 restart");
        drive(0,0,0,0,0, 4'b0000, "R5 gap2");
        // R7: interleaved engines
        drive(1,1,0,0,0, 4'b0010, "R7 e1 after e0");
        drive(1,1,0,0,0, 4'b0001, "R7 e0");
        drive(1,1,0,0,1, 4'b0010, "R7 e1 hold");
        drive(1,1,0,0,1, 4'b0001, "R7 e0 hold");
        drive(1,1,0,0,1, 4'b1000, "R4 host after both pairs");
        drive(0,0,0,0,0, 4'b0000, "R1 idle");
        // R9 / R8 / R10: transfer controller
        drive(0,0,1,0,1, 4'b1000, "R9 host beats new xfr");
        drive(0,0,1,0,0, 4'b0100, "R8 xfr first access");
        drive(1,0,0,0,0, 4'b0001, "R8 engine while xfr quiet");
        drive(1,0,1,0,1, 4'b0100, "R8 busy xfr beats mid-pair");
        drive(1,0,1,1,1, 4'b0100, "R10 last access");
        drive(1,0,1,0,1, 4'b0001, "R10 engine hold restored");
        drive(1,0,1,0,1, 4'b1000, "R10 host beats new xfr");
        drive(0,0,1,0,0, 4'b0100, "R8 xfr start");
        drive(0,0,1,0,1, 4'b0100, "R9 busy xfr beats host");
        drive(0,0,1,1,0, 4'b0100, "R10 final");
        drive(0,0,1,0,1, 4'b1000, "R10 lock gone");
        drive(0,0,0,0,0, 4'b0000, "R1 idle end");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule